// File: doc/BRIEF.md
# Parallel EPROM Read Sequencer

This block sits on the host side of a bank of asynchronous byte-wide EPROMs. Each device has an 18-bit word address, an 8-bit data bus and two active-low controls: a per-device select that also controls power, and a read strobe that gates the output drivers. The host issues a request that carries a bank index and a word address. The sequencer latches the request and places the address on the shared address lines. It then pulls low the select of the one addressed device and drops the shared read strobe late enough that the strobe's own delay ends exactly when the address access time ends. At that edge it captures the byte. It then releases both controls and waits out the output-float time before it takes another request.

All three device timings are given as parameters in picoseconds, together with the clock period. Each one is rounded up to whole clock cycles. The selects of the devices that are not addressed stay high, so those devices sit in standby and never drive the shared data lines.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, every mem_ce_n bit is 1, mem_oe_n is 1 and rsp_done is 0.
- R2: The top BANK_W bits of req_addr pick a device index b. Only mem_ce_n[b] goes low for that request, and at most one mem_ce_n bit is low in any cycle.
- R3: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from that edge until the float wait ends. A req_addr change or a held req_valid while busy starts no second access and does not disturb the current one.
- R4: The selected mem_ce_n stays low for exactly ACC cycles, where ACC = ceil(T_ACC_PS / T_CLK_PS), with a minimum of 1 (11 at the defaults).
- R5: mem_oe_n is low only while a select is low, and it is low for exactly the last OE cycles of the select window, where OE = ceil(T_OE_PS / T_CLK_PS) limited to the range 1..ACC (6 at the defaults).
- R6: The byte on mem_dq_in is captured on the edge that closes the select window. rsp_done is a one-cycle pulse visible ACC edges after the accepting edge. rsp_data holds the byte until the next rsp_done.
- R7: The low ADDR_W bits of req_addr appear on mem_addr and stay unchanged for as long as a select is low.
- R8: After the window closes, req_ready returns exactly ACC + FLT edges after the accepting edge, where FLT = ceil(T_FLT_PS / T_CLK_PS) (6 at the defaults). No select falls fewer than FLT cycles after the previous one rose.
- R9: Back-to-back requests to different banks and to the lowest and highest addresses each return the byte stored at their own bank and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | BANK_W+ADDR_W | Bank index (top bits) and word address |
| rsp_done | output | 1 | One-cycle pulse: rsp_data has been updated |
| rsp_data | output | DATA_W | Last byte captured |
| mem_addr | output | ADDR_W | Shared device address lines |
| mem_ce_n | output | 2**BANK_W | Per-device select, active low |
| mem_oe_n | output | 1 | Shared read strobe, active low |
| mem_dq_in | input | DATA_W | Shared device data lines |

## Verification
The bench's device model returns a poison byte until the select has been low for ACC cycles and the strobe for OE cycles. A sequencer that samples one edge early, or that drops the strobe too late, therefore returns the wrong data instead of the stored byte. Each read counts its select and strobe cycles separately, so a window off by one in either count is reported even when the data happens to be right. A monitor measures the high gap between successive selects during back-to-back reads, which catches a design that skips or shortens the float wait. A held request whose address changes during the access must not change mem_addr, must not be taken twice, and must return its own byte.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rd_state_e;

  // whole clock cycles needed to cover a delay, rounded up
  function automatic int cycles_for(input int delay_ps, input int clk_ps);
    return (delay_ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/eprom_bank_dec.sv
module eprom_bank_dec #(
  parameter int BANK_W    = 2,
  parameter int NUM_BANKS = 1 << BANK_W
) (
  input  logic [BANK_W-1:0]    bank_sel,
  input  logic                 en,
  output logic [NUM_BANKS-1:0] sel_n
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign sel_n[g] = ~(en && (bank_sel == BANK_W'(g)));
  end

endmodule

// File: rtl/eprom_cycle_timer.sv
module eprom_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
  import eprom_rd_pkg::*;
#(
  parameter int ACC_CYC = 11,
  parameter int OE_CYC  = 6,
  parameter int FLT_CYC = 6,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_d,
  output logic             tmr_clr,
  output logic             tmr_en,
  output logic             ce_act_d,
  output logic             oe_n_q,
  output logic             capture
);

  localparam int ACC_LAST = ACC_CYC - 1;
  localparam int FLT_LAST = (FLT_CYC > 0) ? FLT_CYC - 1 : 0;
  localparam int OE_START = ACC_CYC - OE_CYC;

  rd_state_e state_q, state_d;
  logic      oe_n_d;

  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    tmr_clr = 1'b0;
    tmr_en  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_ACCESS;
          tmr_clr = 1'b1;
        end
      end
      ST_ACCESS: begin
        if (cnt_q == CNT_W'(ACC_LAST)) begin
          capture = 1'b1;
          tmr_clr = 1'b1;
          state_d = (FLT_CYC == 0) ? ST_IDLE : ST_FLOAT;
        end else begin
          tmr_en = 1'b1;
        end
      end
      ST_FLOAT: begin
        if (cnt_q == CNT_W'(FLT_LAST)) begin
          state_d = ST_IDLE;
          tmr_clr = 1'b1;
        end else begin
          tmr_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // strobe covers the tail of the select window
  assign ce_act_d = (state_d == ST_ACCESS);
  assign oe_n_d   = !(ce_act_d && (cnt_d >= CNT_W'(OE_START)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      oe_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      oe_n_q  <= oe_n_d;
    end
  end

  // R4: the window counter never passes the last access cycle
  a_r4_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACCESS) |-> (cnt_q <= CNT_W'(ACC_LAST)));

  // R5: the strobe is only ever active inside an access
  a_r5_oe_only_access: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> (state_q == ST_ACCESS));

  // R3: a taken request always starts an access
  a_r3_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (state_q == ST_ACCESS));

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int BANK_W    = 2,
  parameter int T_CLK_PS  = 5000,
  parameter int T_ACC_PS  = 55000,
  parameter int T_OE_PS   = 30000,
  parameter int T_FLT_PS  = 30000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [BANK_W+ADDR_W-1:0]   req_addr,
  output logic                       rsp_done,
  output logic [DATA_W-1:0]          rsp_data,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [(1<<BANK_W)-1:0]     mem_ce_n,
  output logic                       mem_oe_n,
  input  logic [DATA_W-1:0]          mem_dq_in
);

  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int ACC_RAW   = cycles_for(T_ACC_PS, T_CLK_PS);
  localparam int ACC_CYC   = (ACC_RAW < 1) ? 1 : ACC_RAW;
  localparam int OE_RAW    = cycles_for(T_OE_PS, T_CLK_PS);
  localparam int OE_CYC    = (OE_RAW < 1) ? 1 : ((OE_RAW > ACC_CYC) ? ACC_CYC : OE_RAW);
  localparam int FLT_CYC   = cycles_for(T_FLT_PS, T_CLK_PS);
  localparam int MAX_CYC   = (ACC_CYC > FLT_CYC) ? ACC_CYC : FLT_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 tmr_clr, tmr_en, ce_act_d, capture, accept;
  logic [BANK_W-1:0]    bank_q, bank_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [NUM_BANKS-1:0] ce_n_d, ce_n_q;
  logic                 done_q;
  logic [DATA_W-1:0]    data_q;

  eprom_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d)
  );

  eprom_rd_seq #(
    .ACC_CYC (ACC_CYC),
    .OE_CYC  (OE_CYC),
    .FLT_CYC (FLT_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cnt_q     (cnt_q),
    .cnt_d     (cnt_d),
    .tmr_clr   (tmr_clr),
    .tmr_en    (tmr_en),
    .ce_act_d  (ce_act_d),
    .oe_n_q    (mem_oe_n),
    .capture   (capture)
  );

  assign accept = req_valid && req_ready;

  always_comb begin
    bank_d = bank_q;
    addr_d = addr_q;
    if (accept) begin
      bank_d = req_addr[BANK_W+ADDR_W-1:ADDR_W];
      addr_d = req_addr[ADDR_W-1:0];
    end
  end

  // selects decoded from next state, then registered: no glitches at the pins
  eprom_bank_dec #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .bank_sel (bank_d),
    .en       (ce_act_d),
    .sel_n    (ce_n_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      addr_q <= '0;
      ce_n_q <= '1;
      done_q <= 1'b0;
    end else begin
      bank_q <= bank_d;
      addr_q <= addr_d;
      ce_n_q <= ce_n_d;
      done_q <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= mem_dq_in;
  end

  assign mem_addr = addr_q;
  assign mem_ce_n = ce_n_q;
  assign rsp_done = done_q;
  assign rsp_data = data_q;

  // released-select run length, for the float-gap check
  logic [CNT_W-1:0] rel_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_run_q <= CNT_W'(FLT_CYC);
    else if (&mem_ce_n) begin
      if (rel_run_q < CNT_W'(FLT_CYC)) rel_run_q <= rel_run_q + CNT_W'(1);
    end else rel_run_q <= '0;
  end

  // R2: never two devices selected
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ce_n));

  // R5: strobe low implies some device selected
  a_r5_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !(&mem_ce_n));

  // R3: while able to take a request the bus is released
  a_r3_ready_released: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((&mem_ce_n) && mem_oe_n));

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R7: address held while a select stays low
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&mem_ce_n) && !$past(&mem_ce_n)) |-> $stable(mem_addr));

  // R8: a select only falls after the float time has elapsed
  a_r8_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&mem_ce_n) && $past(&mem_ce_n)) |-> (rel_run_q >= CNT_W'(FLT_CYC)));

endmodule

// File: tb/eprom_rd_ctrl_bench.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_bench;

  localparam int T_CLK_PS = 5000;
  localparam int T_ACC_PS = 55000;
  localparam int T_OE_PS  = 30000;
  localparam int T_FLT_PS = 30000;
  localparam int E_ACC    = (T_ACC_PS + T_CLK_PS - 1) / T_CLK_PS;
  localparam int E_OE     = (T_OE_PS + T_CLK_PS - 1) / T_CLK_PS;
  localparam int E_FLT    = (T_FLT_PS + T_CLK_PS - 1) / T_CLK_PS;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [19:0] req_addr;
  logic        rsp_done;
  logic [7:0]  rsp_data;
  logic [17:0] mem_addr;
  logic [3:0]  mem_ce_n;
  logic        mem_oe_n;
  logic [7:0]  mem_dq_in;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  eprom_rd_ctrl #(
    .T_CLK_PS (T_CLK_PS),
    .T_ACC_PS (T_ACC_PS),
    .T_OE_PS  (T_OE_PS),
    .T_FLT_PS (T_FLT_PS)
  ) u_eprom_rd_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_done  (rsp_done),
    .rsp_data  (rsp_data),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_in (mem_dq_in)
  );

  function automatic logic [7:0] pat(input logic [1:0] b, input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {b, a[17:16], 4'h9};
  endfunction

  // device model: poison byte until access and strobe delays have elapsed
  int ce_run, oe_run;
  logic [1:0] sel_idx;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_run <= 0;
      oe_run <= 0;
    end else begin
      ce_run <= (~&mem_ce_n) ? ce_run + 1 : 0;
      oe_run <= ((~&mem_ce_n) && !mem_oe_n) ? oe_run + 1 : 0;
    end
  end
  always_comb begin
    sel_idx = 2'd0;
    for (int i = 0; i < 4; i++) if (!mem_ce_n[i]) sel_idx = 2'(i);
    if ((~&mem_ce_n) && !mem_oe_n)
      mem_dq_in = ((ce_run + 1 >= E_ACC) && (oe_run + 1 >= E_OE)) ? pat(sel_idx, mem_addr) : 8'hEE;
    else
      mem_dq_in = 8'h5A;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R8 gap monitor between a select rising and the next one falling
  int  gap = 0;
  bit  seen_low = 0;
  bit  prev_high = 1;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (&mem_ce_n) gap++;
      else begin
        if (seen_low && prev_high)
          chk(gap >= E_FLT, "R8", "float gap cycles", gap, E_FLT);
        gap = 0;
        seen_low = 1;
      end
      prev_high = &mem_ce_n;
    end
  end

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(mem_ce_n === 4'hF, "R1", "selects in reset", mem_ce_n, 4'hF);
    chk(mem_oe_n === 1'b1, "R1", "strobe in reset", mem_oe_n, 1);
    chk(rsp_done === 1'b0, "R1", "done in reset", rsp_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && mem_ce_n === 4'hF, "R1", "idle after reset",
        {req_ready, mem_ce_n}, 5'h1F);
  endtask

  // caller is at a negedge; request goes out at once
  task automatic do_read(input logic [1:0] b, input logic [17:0] a);
    logic [7:0] got = 8'h00;
    int lat_done = -1, lat_rdy = -1, ce_cnt = 0, oe_cnt = 0, done_cnt = 0;
    bit addr_ok = 1, other_ok = 1;
    logic [3:0] oth;
    req_valid = 1'b1;
    req_addr  = {b, a};
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int j = 0; j < 200; j++) begin
      @(negedge clk);
      if (!mem_ce_n[b]) begin
        ce_cnt++;
        if (mem_addr !== a) addr_ok = 0;
      end
      oth = ~mem_ce_n;
      oth[b] = 1'b0;
      if (|oth) other_ok = 0;
      if (!mem_oe_n) oe_cnt++;
      if (rsp_done) begin
        done_cnt++;
        lat_done = j;
        got = rsp_data;
      end
      if (req_ready) begin
        lat_rdy = j;
        break;
      end
    end
    chk(got === pat(b, a), "R9", "read data", got, pat(b, a));
    chk(lat_done == E_ACC, "R6", "done latency", lat_done, E_ACC);
    chk(done_cnt == 1, "R6", "done pulse count", done_cnt, 1);
    chk(rsp_data === got, "R6", "data held after done", rsp_data, got);
    chk(ce_cnt == E_ACC, "R4", "select low cycles", ce_cnt, E_ACC);
    chk(oe_cnt == E_OE, "R5", "strobe low cycles", oe_cnt, E_OE);
    chk(lat_rdy == E_ACC + E_FLT, "R8", "ready latency", lat_rdy, E_ACC + E_FLT);
    chk(addr_ok, "R7", "address held in window", addr_ok, 1);
    chk(other_ok, "R2", "only addressed select low", other_ok, 1);
  endtask

  task automatic t_single();
    @(negedge clk);
    do_read(2'd0, 18'h00000);
  endtask

  task automatic t_banks();
    do_read(2'd1, 18'h12345);
    do_read(2'd2, 18'h2A5C3);
    do_read(2'd3, 18'h3FFFF);
    do_read(2'd0, 18'h0F0F0);
  endtask

  task automatic t_back_to_back();
    do_read(2'd3, 18'h00001);
    do_read(2'd1, 18'h3FFFE);
    do_read(2'd1, 18'h1C0DE);
  endtask

  // request held valid while its address changes during the access
  task automatic t_held();
    logic [17:0] a0 = 18'h0BEEF;
    logic [17:0] a1 = 18'h35A17;
    logic [7:0]  d[2];
    int n_done = 0, extra = 0;
    bit b_sent = 0, addr_ok = 1;
    d[0] = 8'h00; d[1] = 8'h00;
    req_valid = 1'b1;
    req_addr  = {2'd1, a0};
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_addr = {2'd2, a1};
    for (int j = 0; j < 300; j++) begin
      @(negedge clk);
      if (!mem_ce_n[1] && mem_addr !== a0) addr_ok = 0;
      if (rsp_done) begin
        if (n_done < 2) d[n_done] = rsp_data;
        n_done++;
      end
      if (req_ready) begin
        if (!b_sent) begin
          @(posedge clk);
          #1 req_valid = 1'b0;
          b_sent = 1;
        end else break;
      end
    end
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (rsp_done || !(&mem_ce_n)) extra++;
    end
    chk(addr_ok, "R3", "address unchanged by busy input", addr_ok, 1);
    chk(d[0] === pat(2'd1, a0), "R3", "first held request data", d[0], pat(2'd1, a0));
    chk(d[1] === pat(2'd2, a1), "R3", "second request data", d[1], pat(2'd2, a1));
    chk(n_done == 2, "R3", "accesses for two requests", n_done, 2);
    chk(extra == 0, "R3", "no access after valid drop", extra, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_banks();
    t_back_to_back();
    t_held();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule